// File: doc/BRIEF.md
# SAR ADC Timing Sequencer

This block is the digital control half of a successive-approximation converter. A start pulse launches one conversion: the block latches the source selection, the resolution bit and an 8-bit timing word, holds the analog sample switch closed for a programmed number of clock periods, and then runs one bit trial per result bit from the most significant bit down. During each trial it presents a trial code to the capacitor DAC. It reads a single comparator bit at the end of the trial to decide whether that bit stays set.

Once the last trial and a short settling tail are over, the result and a done flag appear. Both stay in place until the next accepted start. Besides the pin channels, two test sources can be converted: analog ground and the reference input. A timing word with an out-of-range field, or an out-of-range pin channel, is refused. It raises an error flag and no conversion starts.

There is no back-pressure. The result is a plain status output: it is valid while `done` is high and it is replaced only by a later conversion. A consumer that needs it must read it before it issues the next start.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, `busy`, `done`, `cfg_err`, `sample_en`, the three source enables, `mux_chan`, `dac_code` and `result` are all zero.
- R2: The sample field is `timing[7:5]` (S). When a start is accepted, `sample_en` is high for exactly 8*S+2 cycles, beginning in the cycle after the accepting clock edge.
- R3: The conversion field is `timing[4:0]` (C). Each bit trial lasts 2*(C+1) cycles. `done` rises B*2*(C+1)+3 cycles after `sample_en` falls, where B is the result width.
- R4: Trials run MSB first. In the first trial, `dac_code` is 1<<(B-1). Each later trial code is the bits kept so far plus the bit under trial. A bit is kept when `cmp_ge` is 1 at the end of its trial, so the result is the largest B-bit code not above the held input. The result is right-aligned.
- R5: `mode10`=1 selects B=10. `mode10`=0 selects B=8, and in that case `result[9:8]` and `dac_code[9:8]` stay 0.
- R6: `src_sel` 00 selects pin channel `chan`, 01 selects analog ground and 1x selects the reference. Exactly one of `pin_en`, `gnd_en` and `ref_en` is high while `sample_en` is high, and none is high otherwise. `mux_chan` carries the channel while `pin_en` is high and is 0 otherwise.
- R7: A start while `busy` is high is ignored. The running conversion keeps its timing, source and result, even if the inputs change.
- R8: `done` and `result` hold until the next accepted start. That start clears `done` in the following cycle.
- R9: If S=0 or C<2, the start sets `cfg_err` and no conversion starts: `busy`, `sample_en` and `done` stay 0. The next accepted valid start clears `cfg_err`.
- R10: If pin source is selected and `chan` is 13 or above, the start sets `cfg_err`. The channel value is ignored for the ground and reference sources.
- R11: `busy` is high from the cycle after an accepted start until the cycle in which `done` rises, and it is never high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request pulse |
| timing | input | 8 | Sample field [7:5], conversion field [4:0] |
| mode10 | input | 1 | 1 = 10-bit result, 0 = 8-bit result |
| src_sel | input | 2 | 00 pin, 01 ground, 1x reference |
| chan | input | 4 | Pin channel number, 0 to 12 |
| cmp_ge | input | 1 | Comparator: held input >= DAC code |
| sample_en | output | 1 | Sample switch closed |
| pin_en | output | 1 | Pin channel routed to the sampler |
| gnd_en | output | 1 | Ground routed to the sampler |
| ref_en | output | 1 | Reference routed to the sampler |
| mux_chan | output | 4 | Routed pin channel |
| dac_code | output | 10 | Trial code for the capacitor DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Result valid |
| cfg_err | output | 1 | Last start refused |
| result | output | 10 | Conversion result |

## Verification
The bench targets the cycle counts at the extremes of both fields: S=1 with C=2, and S=7 with C=31. A sample or trial counter that is off by one shifts the trial boundaries and the `done` cycle. The bench probes those edges cycle by cycle. Both resolutions are converted with inputs above full scale, plus ground and reference. An MSB that is misplaced for 8-bit mode, or a keep decision with the wrong sense, then yields a wrong result. A start pulse in mid-conversion with changed inputs, refused timing words, C=1 at the lower bound, and a high channel number under the ground source expose a sequencer that restarts, that latches its inputs late, or that range-checks the channel when it should not.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_TRIAL  = 2'd2,
    ST_TAIL   = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_PIN = 2'd0,
    SRC_GND = 2'd1,
    SRC_REF = 2'd2
  } src_e;

  // reference wins over ground when both bits are set
  function automatic src_e decode_src(input logic [1:0] sel);
    if (sel[1]) return SRC_REF;
    if (sel[0]) return SRC_GND;
    return SRC_PIN;
  endfunction

endpackage

// File: rtl/adc_time_decode.sv
module adc_time_decode #(
  parameter int SAM_W    = 3,
  parameter int CONV_W   = 5,
  parameter int CNT_W    = 7,
  parameter int SAM_MIN  = 1,
  parameter int CONV_MIN = 2
) (
  input  logic [SAM_W+CONV_W-1:0] timing,
  output logic [CNT_W-1:0]        sample_cycles,
  output logic [CNT_W-1:0]        trial_cycles,
  output logic                    cfg_ok
);
  localparam int TIME_W = SAM_W + CONV_W;

  logic [SAM_W-1:0]  sam;
  logic [CONV_W-1:0] conv;

  assign sam  = timing[TIME_W-1 -: SAM_W];
  assign conv = timing[CONV_W-1:0];

  // sample window 8*S+2, one trial 2*(C+1)
  assign sample_cycles = (CNT_W'(sam) << 3) + CNT_W'(2);
  assign trial_cycles  = (CNT_W'(conv) + CNT_W'(1)) << 1;
  assign cfg_ok        = (sam >= SAM_W'(SAM_MIN)) && (conv >= CONV_W'(CONV_MIN));
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES_W  = 10,
  parameter int RES_LO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             wide,
  input  logic             step,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] kept,
  output logic [RES_W-1:0] trial_code,
  output logic             last_trial
);
  localparam logic [RES_W-1:0] TOP_HI = RES_W'(1) << (RES_W - 1);
  localparam logic [RES_W-1:0] TOP_LO = RES_W'(1) << (RES_LO - 1);

  logic [RES_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept <= '0;
      mask <= '0;
    end else if (load) begin
      kept <= '0;
      mask <= wide ? TOP_HI : TOP_LO;
    end else if (step) begin
      if (cmp_ge) kept <= kept | mask;
      mask <= mask >> 1;
    end
  end

  assign trial_code = kept | mask;
  assign last_trial = mask[0];
endmodule

// File: rtl/adc_input_select.sv
module adc_input_select
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            active,
  input  src_e            src,
  input  logic [CH_W-1:0] chan_q,
  output logic            pin_en,
  output logic            gnd_en,
  output logic            ref_en,
  output logic [CH_W-1:0] mux_chan
);
  always_comb begin
    pin_en   = 1'b0;
    gnd_en   = 1'b0;
    ref_en   = 1'b0;
    mux_chan = '0;
    if (active) begin
      unique case (src)
        SRC_PIN: begin
          pin_en   = 1'b1;
          mux_chan = chan_q;
        end
        SRC_GND: gnd_en = 1'b1;
        default: ref_en = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int SAM_W    = 3,
  parameter int CONV_W   = 5,
  parameter int RES_W    = 10,
  parameter int RES_LO   = 8,
  parameter int NUM_CH   = 13,
  parameter int CH_W     = 4,
  parameter int TAIL_CYC = 3,
  parameter int SAM_MIN  = 1,
  parameter int CONV_MIN = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [SAM_W+CONV_W-1:0] timing,
  input  logic                    mode10,
  input  logic [1:0]              src_sel,
  input  logic [CH_W-1:0]         chan,
  input  logic                    cmp_ge,
  output logic                    sample_en,
  output logic                    pin_en,
  output logic                    gnd_en,
  output logic                    ref_en,
  output logic [CH_W-1:0]         mux_chan,
  output logic [RES_W-1:0]        dac_code,
  output logic                    busy,
  output logic                    done,
  output logic                    cfg_err,
  output logic [RES_W-1:0]        result
);
  localparam int CNT_W = (SAM_W + 3 > CONV_W + 2) ? SAM_W + 3 : CONV_W + 2;

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] trial_len;
  logic [CNT_W-1:0] sample_cycles;
  logic [CNT_W-1:0] trial_cycles;
  logic             time_ok;
  logic             chan_ok;
  logic             go_ok;
  logic             wide_q;
  src_e             src_q;
  src_e             src_in;
  logic [CH_W-1:0]  chan_q;
  logic             done_q;
  logic             err_q;
  logic [RES_W-1:0] result_q;
  logic [RES_W-1:0] kept;
  logic [RES_W-1:0] trial_code;
  logic             last_trial;
  logic             sar_load;
  logic             sar_step;

  adc_time_decode #(
    .SAM_W(SAM_W), .CONV_W(CONV_W), .CNT_W(CNT_W),
    .SAM_MIN(SAM_MIN), .CONV_MIN(CONV_MIN)
  ) u_decode (
    .timing       (timing),
    .sample_cycles(sample_cycles),
    .trial_cycles (trial_cycles),
    .cfg_ok       (time_ok)
  );

  assign src_in  = decode_src(src_sel);
  assign chan_ok = (src_in != SRC_PIN) || (int'(chan) < NUM_CH);
  assign go_ok   = time_ok && chan_ok;

  assign sar_load = (state == ST_SAMPLE) && (cnt == '0);
  assign sar_step = (state == ST_TRIAL) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      trial_len <= '0;
      wide_q    <= 1'b0;
      src_q     <= SRC_PIN;
      chan_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      result_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            done_q <= 1'b0;
            err_q  <= !go_ok;
            if (go_ok) begin
              state     <= ST_SAMPLE;
              cnt       <= sample_cycles - CNT_W'(1);
              trial_len <= trial_cycles;
              wide_q    <= mode10;
              src_q     <= src_in;
              chan_q    <= chan;
            end
          end
        end
        ST_SAMPLE: begin
          if (cnt == '0) begin
            state <= ST_TRIAL;
            cnt   <= trial_len - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_TRIAL: begin
          if (cnt == '0) begin
            if (last_trial) begin
              state <= ST_TAIL;
              cnt   <= CNT_W'(TAIL_CYC - 1);
            end else begin
              cnt <= trial_len - CNT_W'(1);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            state    <= ST_IDLE;
            done_q   <= 1'b1;
            result_q <= kept;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      endcase
    end
  end

  adc_sar_reg #(
    .RES_W(RES_W), .RES_LO(RES_LO)
  ) u_sar (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sar_load),
    .wide      (wide_q),
    .step      (sar_step),
    .cmp_ge    (cmp_ge),
    .kept      (kept),
    .trial_code(trial_code),
    .last_trial(last_trial)
  );

  adc_input_select #(
    .CH_W(CH_W)
  ) u_sel (
    .active  (state == ST_SAMPLE),
    .src     (src_q),
    .chan_q  (chan_q),
    .pin_en  (pin_en),
    .gnd_en  (gnd_en),
    .ref_en  (ref_en),
    .mux_chan(mux_chan)
  );

  assign sample_en = (state == ST_SAMPLE);
  assign busy      = (state != ST_IDLE);
  assign dac_code  = (state == ST_TRIAL) ? trial_code : '0;
  assign done      = done_q;
  assign cfg_err   = err_q;
  assign result    = result_q;
endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             sample_en,
  input logic             pin_en,
  input logic             gnd_en,
  input logic             ref_en,
  input logic [RES_W-1:0] dac_code,
  input logic             busy,
  input logic             done,
  input logic             cfg_err,
  input logic [RES_W-1:0] result
);
  // R2
  sample_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy);

  // R6
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pin_en, gnd_en, ref_en}));

  // R6
  source_only_sampling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en || gnd_en || ref_en) |-> sample_en);

  // R4
  first_trial_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_en) && busy) |-> ($countones(dac_code) == 1));

  // R4
  dac_only_in_trials_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != '0) |-> (busy && !sample_en));

  // R7
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(result));

  // R9
  err_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind adc_sar_seq adc_sar_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .sample_en(sample_en),
  .pin_en   (pin_en),
  .gnd_en   (gnd_en),
  .ref_en   (ref_en),
  .dac_code (dac_code),
  .busy     (busy),
  .done     (done),
  .cfg_err  (cfg_err),
  .result   (result)
);

// File: tb/test_adc_sar_seq.sv
module test_adc_sar_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] timing = '0;
  logic       mode10 = 1'b0;
  logic [1:0] src_sel = '0;
  logic [3:0] chan = '0;
  logic       cmp_ge;
  logic       sample_en, pin_en, gnd_en, ref_en, busy, done, cfg_err;
  logic [3:0] mux_chan;
  logic [9:0] dac_code, result;
  logic [9:0] held = '0;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  adc_sar_seq i_adc_sar_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .timing(timing), .mode10(mode10),
    .src_sel(src_sel), .chan(chan), .cmp_ge(cmp_ge), .sample_en(sample_en),
    .pin_en(pin_en), .gnd_en(gnd_en), .ref_en(ref_en), .mux_chan(mux_chan),
    .dac_code(dac_code), .busy(busy), .done(done), .cfg_err(cfg_err),
    .result(result)
  );

  function automatic int pin_v(input int i);
    return (i * 77 + 5) % 1024;
  endfunction

  // sample-and-hold plus comparator model
  always @(posedge clk) begin
    if (pin_en) held <= 10'(pin_v(int'(mux_chan)));
    else if (gnd_en) held <= '0;
    else if (ref_en) held <= 10'd1023;
  end
  assign cmp_ge = (held >= dac_code);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input int sam, input int conv, input bit m10,
                             input int src, input int ch);
    @(negedge clk);
    timing  = 8'((sam << 5) | conv);
    mode10  = m10;
    src_sel = 2'(src);
    chan    = 4'(ch);
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  // full conversion; poke>0 pulses start with changed inputs at that cycle
  task automatic t_conv(input string nm, input int sam, input int conv, input bit m10,
                        input int src, input int ch, input int poke);
    int b, ts, tb, tot, exp, msb, j, samp, fullv;
    b     = m10 ? 10 : 8;
    ts    = 8 * sam + 2;
    tb    = 2 * (conv + 1);
    tot   = ts + b * tb + 3;
    fullv = (1 << b) - 1;
    msb   = 1 << (b - 1);
    if (src == 0) exp = pin_v(ch);
    else if (src == 1) exp = 0;
    else exp = 1023;
    if (exp > fullv) exp = fullv;
    pulse_start(sam, conv, m10, src, ch);
    j = 0;
    samp = 0;
    chk(busy && !done && !cfg_err, {nm, " R11 busy after start"}, {busy, done, cfg_err}, 4);
    chk(sample_en, {nm, " R2 sample starts"}, sample_en, 1);
    if (src == 0)
      chk(pin_en && !gnd_en && !ref_en && mux_chan == 4'(ch), {nm, " R6 pin route"},
          mux_chan, ch);
    else if (src == 1)
      chk(gnd_en && !pin_en && !ref_en, {nm, " R6 ground route"}, {pin_en, gnd_en, ref_en}, 2);
    else
      chk(ref_en && !pin_en && !gnd_en, {nm, " R6 ref route"}, {pin_en, gnd_en, ref_en}, 1);
    while (!done && j < 4000) begin
      if (sample_en) samp++;
      if (j == ts) begin
        chk(int'(dac_code) == msb, {nm, " R4 R5 first trial code"}, dac_code, msb);
        chk(!pin_en && !gnd_en && !ref_en, {nm, " R6 route off"}, {pin_en, gnd_en, ref_en}, 0);
      end
      if (j == ts + tb - 1)
        chk(int'(dac_code) == msb, {nm, " R3 trial length"}, dac_code, msb);
      if (j == ts + tb)
        chk(int'(dac_code) == ((exp & msb) | (msb >> 1)), {nm, " R3 R4 second trial"},
            dac_code, (exp & msb) | (msb >> 1));
      if (poke > 0 && j == poke) begin
        timing = 8'h22; src_sel = 2'b10; mode10 = ~m10; chan = 4'd1; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      j++;
    end
    start = 1'b0;
    chk(samp == ts, {nm, " R2 sample cycles"}, samp, ts);
    chk(j == tot, {nm, " R3 done cycle"}, j, tot);
    chk(int'(result) == exp, {nm, " R4 R5 result"}, result, exp);
    chk(!busy, {nm, " R11 idle at done"}, busy, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !cfg_err && !sample_en, "R1 reset flags",
        {busy, done, cfg_err, sample_en}, 0);
    chk(!pin_en && !gnd_en && !ref_en && mux_chan == 0, "R1 reset route",
        {pin_en, gnd_en, ref_en, mux_chan}, 0);
    chk(dac_code == 0 && result == 0, "R1 reset codes", result, 0);
  endtask

  task automatic t_hold();
    logic [9:0] r;
    r = result;
    repeat (10) @(negedge clk);
    chk(done, "R8 done holds", done, 1);
    chk(result == r, "R8 result holds", result, r);
    pulse_start(2, 4, 1'b1, 1, 0);
    chk(!done && busy, "R8 start clears done", {done, busy}, 1);
    while (!done) @(negedge clk);
    chk(result == 0, "R8 new result ground", result, 0);
  endtask

  task automatic t_bad(input string nm, input int sam, input int conv, input int src,
                       input int ch);
    pulse_start(sam, conv, 1'b1, src, ch);
    chk(cfg_err, {nm, " flag set"}, cfg_err, 1);
    chk(!busy && !sample_en && !done, {nm, " no conversion"}, {busy, sample_en, done}, 0);
    repeat (4) @(negedge clk);
    chk(!busy && !sample_en && !done, {nm, " stays idle"}, {busy, sample_en, done}, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_conv("min timing 10b", 1, 2, 1'b1, 0, 3, 0);
    t_conv("max timing 8b sat", 7, 31, 1'b0, 0, 12, 0);
    t_conv("8b pin low", 1, 3, 1'b0, 0, 0, 0);
    t_conv("10b ch12", 2, 4, 1'b1, 0, 12, 0);
    t_conv("ground 10b", 2, 5, 1'b1, 1, 9, 0);
    t_conv("ref 8b", 3, 9, 1'b0, 2, 0, 0);
    t_conv("R7 start while busy", 4, 3, 1'b1, 0, 7, 40);
    t_hold();
    t_bad("R9 sam zero", 0, 10, 0, 1);
    t_conv("R9 clear err", 1, 2, 1'b1, 0, 5, 0);
    t_bad("R9 conv one", 3, 1, 0, 1);
    t_bad("R9 conv zero", 3, 0, 1, 1);
    t_bad("R10 chan 13", 2, 4, 0, 13);
    t_conv("R10 chan ignored gnd", 1, 2, 1'b1, 1, 15, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule